// File: doc/BRIEF.md
# Dispatch Group Packer

The packer sits between a decoder that has already split complex instructions into micro-operations and the dispatch stage of an out-of-order core. It takes one tagged micro-op per accepted handshake and assembles dispatch groups of five slots. A finished group is held in an output register until the downstream resource check reports that every slot can be served in the same cycle. The whole group then leaves at once. At most one group leaves per clock.

Each micro-op carries a payload and four tags: branch, head of a cracked sequence (with the sequence length), writer of a non-renamed register, and serializing. Fixed packing rules decide where each op lands and when a group closes: the last slot carries only branches, cracked sequences are kept whole, non-renamed writers end their group, and serializing ops travel alone. Unused slots go out as NOPs. A partly built group is also sent when the input runs dry.

Top module: `grp_former`

## Requirements
- R1: After synchronous reset `grp_valid` is 0 and every bit of `grp_slot_vld` is 0.
- R2: Slot 4 (the last slot, index NSLOT-1) only ever holds a branch. Four non-branch ops fill slots 0..3, and a following non-branch op starts a new group, so slot 4 goes out as a NOP.
- R3: A branch is always placed in slot 4 and closes its group. Any slots from the current fill point up to slot 3 go out as NOPs. A NOP slot has valid bit 0 and payload 0.
- R4: A cracked-sequence head with length L (1..4) is placed only if the used slot count plus L is at most 4. Otherwise the current group is sent padded and the sequence starts a fresh group. All L ops then share one group.
- R5: An op that writes a non-renamed register is placed at the next free slot of slots 0..3 and closes the group. If slots 0..3 are full, the old group is sent first.
- R6: A serializing op goes out as a group holding only that op in slot 0. A partly built group is sent before it, and the op after it starts a new group.
- R7: While `grp_valid` is 1 and `disp_ok` is 0, the group outputs stay unchanged. A held group leaves at a clock edge where `disp_ok` is 1, and at most one group leaves per clock.
- R8: When `in_valid` is 0 and a partly built group exists that is not in the middle of a cracked sequence, that group is sent padded with NOPs. A gap inside a cracked sequence does not split it.
- R9: Four non-branch ops followed by a branch give one full group: slots 0..3 hold the ops and slot 4 holds the branch.
- R10: Ops after the head of a cracked sequence are placed as plain ops, and their tags are ignored. Tag priority for other ops is serializing, then branch, then crack head, then non-renamed writer.
- R11: Every accepted op appears exactly once, in input order, reading the groups in order of leaving and each group from slot 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A micro-op is offered |
| in_ready | output | 1 | The offered micro-op is taken at this edge |
| in_pay | input | 8 | Micro-op payload |
| in_branch | input | 1 | Op is a branch |
| in_crack_first | input | 1 | Op heads a cracked sequence |
| in_crack_len | input | 3 | Ops in the sequence, 1..4 (read with the head) |
| in_nonren | input | 1 | Op writes a non-renamed register |
| in_serialize | input | 1 | Op must run alone |
| disp_ok | input | 1 | Resources for the whole held group are available |
| grp_valid | output | 1 | A group is held at the output |
| grp_slot_vld | output | 5 | Per-slot valid bit, 0 means NOP |
| grp_slot_pay | output | 40 | Per-slot payload, slot i at bits [8i+7:8i] |

## Verification
A wrong fill count or leftover crack counter does not hide. It moves the next op into the wrong slot or splits or merges a group, and that shows in the very next group to leave. A wrong close decision either sends an extra group or puts a non-branch into slot 4, which the slot-by-slot comparison catches when that group is dispatched. A fault in the hold register shows on the first stalled cycle as an output change while `disp_ok` is low.

// File: rtl/grpf_pkg.sv
package grpf_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_PLACE = 2'd1,
    ACT_FLUSH = 2'd2,
    ACT_CLOSE = 2'd3
  } grpf_act_e;

  typedef struct packed {
    logic serialize;
    logic branch;
    logic crack_first;
    logic nonren;
  } grpf_tag_t;
endpackage

// File: rtl/grpf_classify.sv
module grpf_classify
  import grpf_pkg::*;
#(
  parameter int NSLOT = 5,
  parameter int LEN_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             in_valid,
  input  grpf_tag_t        tag,
  input  logic [LEN_W-1:0] len,
  input  logic [CNT_W-1:0] cnt,
  input  logic [LEN_W-1:0] rem,
  input  logic             out_free,
  output grpf_act_e        act,
  output logic [CNT_W-1:0] pos
);
  localparam int LAST = NSLOT - 1;

  logic member;
  logic full;
  logic fits;

  assign member = (rem != '0);
  assign full   = (cnt == CNT_W'(LAST));
  assign fits   = (32'(cnt) + 32'(len)) <= 32'(LAST);

  always_comb begin
    act = ACT_IDLE;
    pos = cnt;
    if (!in_valid) begin
      if (cnt != '0 && !member && out_free) act = ACT_FLUSH;
    end else if (member) begin
      act = ACT_PLACE;
    end else if (tag.serialize) begin
      if (out_free) act = (cnt == '0) ? ACT_CLOSE : ACT_FLUSH;
    end else if (tag.branch) begin
      if (out_free) begin
        act = ACT_CLOSE;
        pos = CNT_W'(LAST);
      end
    end else if (tag.crack_first) begin
      if (fits) act = ACT_PLACE;
      else if (out_free) act = ACT_FLUSH;
    end else if (full) begin
      if (out_free) act = ACT_FLUSH;
    end else if (tag.nonren) begin
      if (out_free) act = ACT_CLOSE;
    end else begin
      act = ACT_PLACE;
    end
  end
endmodule

// File: rtl/grpf_build.sv
module grpf_build
  import grpf_pkg::*;
#(
  parameter int NSLOT = 5,
  parameter int PAY_W = 8,
  parameter int LEN_W = 3,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  grpf_act_e              act,
  input  logic [CNT_W-1:0]       pos,
  input  logic [PAY_W-1:0]       op_pay,
  input  logic                   op_first,
  input  logic [LEN_W-1:0]       op_len,
  output logic [CNT_W-1:0]       cnt,
  output logic [LEN_W-1:0]       rem,
  output logic [NSLOT-1:0]       grp_vld,
  output logic [NSLOT*PAY_W-1:0] grp_pay
);
  localparam int LAST = NSLOT - 1;

  logic [NSLOT-1:0]       b_vld;
  logic [NSLOT*PAY_W-1:0] b_pay;
  logic                   clear;
  logic                   place;
  logic                   close;

  assign clear = (act == ACT_FLUSH) || (act == ACT_CLOSE);
  assign place = (act == ACT_PLACE);
  assign close = (act == ACT_CLOSE);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        b_vld[i]                 <= 1'b0;
        b_pay[i*PAY_W +: PAY_W]  <= '0;
      end else if (place && cnt == CNT_W'(i)) begin
        b_vld[i]                 <= 1'b1;
        b_pay[i*PAY_W +: PAY_W]  <= op_pay;
      end
    end

    assign grp_vld[i] = b_vld[i] | (close && pos == CNT_W'(i));
    assign grp_pay[i*PAY_W +: PAY_W] = (close && pos == CNT_W'(i)) ?
                                       op_pay : b_pay[i*PAY_W +: PAY_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      rem <= '0;
    end else if (place) begin
      cnt <= cnt + 1'b1;
      if (op_first)        rem <= op_len - 1'b1;
      else if (rem != '0)  rem <= rem - 1'b1;
    end
  end

  // R4
  crack_fit_chk: assert property (@(posedge clk) disable iff (rst)
    (rem != '0) |-> ((32'(cnt) + 32'(rem)) <= 32'(LAST)));
endmodule

// File: rtl/grpf_hold.sv
module grpf_hold #(
  parameter int NSLOT = 5,
  parameter int PAY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   disp_ok,
  input  logic [NSLOT-1:0]       grp_vld,
  input  logic [NSLOT*PAY_W-1:0] grp_pay,
  output logic                   o_valid,
  output logic [NSLOT-1:0]       o_vld,
  output logic [NSLOT*PAY_W-1:0] o_pay,
  output logic                   out_free
);
  assign out_free = !o_valid || disp_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_vld   <= '0;
      o_pay   <= '0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_vld   <= grp_vld;
      o_pay   <= grp_pay;
    end else if (disp_ok) begin
      o_valid <= 1'b0;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !disp_ok) |=> (o_valid && $stable(o_vld) && $stable(o_pay)));
endmodule

// File: rtl/grp_former.sv
module grp_former
  import grpf_pkg::*;
#(
  parameter int NSLOT = 5,
  parameter int PAY_W = 8,
  parameter int LEN_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PAY_W-1:0]       in_pay,
  input  logic                   in_branch,
  input  logic                   in_crack_first,
  input  logic [LEN_W-1:0]       in_crack_len,
  input  logic                   in_nonren,
  input  logic                   in_serialize,
  input  logic                   disp_ok,
  output logic                   grp_valid,
  output logic [NSLOT-1:0]       grp_slot_vld,
  output logic [NSLOT*PAY_W-1:0] grp_slot_pay
);
  localparam int LAST  = NSLOT - 1;
  localparam int CNT_W = $clog2(NSLOT);

  grpf_tag_t              tag;
  grpf_act_e              act;
  logic [CNT_W-1:0]       pos;
  logic [CNT_W-1:0]       cnt;
  logic [LEN_W-1:0]       rem;
  logic                   out_free;
  logic                   emit;
  logic                   op_first;
  logic [NSLOT-1:0]       nxt_vld;
  logic [NSLOT*PAY_W-1:0] nxt_pay;

  assign tag      = '{serialize: in_serialize, branch: in_branch,
                      crack_first: in_crack_first, nonren: in_nonren};
  assign in_ready = (act == ACT_PLACE) || (act == ACT_CLOSE);
  assign emit     = (act == ACT_FLUSH) || (act == ACT_CLOSE);
  assign op_first = in_crack_first && (rem == '0);

  grpf_classify #(.NSLOT(NSLOT), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_classify (
    .in_valid (in_valid),
    .tag      (tag),
    .len      (in_crack_len),
    .cnt      (cnt),
    .rem      (rem),
    .out_free (out_free),
    .act      (act),
    .pos      (pos)
  );

  grpf_build #(.NSLOT(NSLOT), .PAY_W(PAY_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_build (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .pos      (pos),
    .op_pay   (in_pay),
    .op_first (op_first),
    .op_len   (in_crack_len),
    .cnt      (cnt),
    .rem      (rem),
    .grp_vld  (nxt_vld),
    .grp_pay  (nxt_pay)
  );

  grpf_hold #(.NSLOT(NSLOT), .PAY_W(PAY_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (emit),
    .disp_ok  (disp_ok),
    .grp_vld  (nxt_vld),
    .grp_pay  (nxt_pay),
    .o_valid  (grp_valid),
    .o_vld    (grp_slot_vld),
    .o_pay    (grp_slot_pay),
    .out_free (out_free)
  );

  // R2
  last_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLOSE && pos == CNT_W'(LAST)) |-> (in_valid && in_branch));

  // R6
  serial_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_serialize && rem == '0) |-> (cnt == '0));

  // R8
  idle_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && cnt != '0 && rem == '0 && out_free) |=> grp_valid);
endmodule

// File: tb/test_grp_former.sv
module test_grp_former;
  localparam int NS = 5;
  localparam int PW = 8;
  localparam int LW = 3;
  localparam int GW = NS + NS * PW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst;
  logic           in_valid;
  logic           in_ready;
  logic [PW-1:0]  in_pay;
  logic           in_branch, in_crack_first, in_nonren, in_serialize;
  logic [LW-1:0]  in_crack_len;
  logic           disp_ok;
  logic           grp_valid;
  logic [NS-1:0]  grp_slot_vld;
  logic [NS*PW-1:0] grp_slot_pay;

  grp_former #(.NSLOT(NS), .PAY_W(PW), .LEN_W(LW)) i_grp_former (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pay(in_pay), .in_branch(in_branch), .in_crack_first(in_crack_first),
    .in_crack_len(in_crack_len), .in_nonren(in_nonren),
    .in_serialize(in_serialize), .disp_ok(disp_ok), .grp_valid(grp_valid),
    .grp_slot_vld(grp_slot_vld), .grp_slot_pay(grp_slot_pay)
  );

  int checks = 0;
  int fails  = 0;
  int nid    = 0;
  int dmode  = 0;
  string phase = "R1";

  logic [GW-1:0] expq[$];
  int            m_cnt = 0;
  int            m_rem = 0;
  logic [NS-1:0]    m_vld = '0;
  logic [NS*PW-1:0] m_pay = '0;

  task automatic check(input bit ok, input string req,
                       input logic [GW-1:0] act, input logic [GW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference packing model, transaction level
  task automatic m_flush();
    expq.push_back({m_vld, m_pay});
    m_vld = '0; m_pay = '0; m_cnt = 0;
  endtask

  task automatic m_place(input logic [PW-1:0] p);
    m_vld[m_cnt] = 1'b1;
    m_pay[m_cnt*PW +: PW] = p;
    m_cnt++;
  endtask

  task automatic model_op(input bit br, input bit cf, input bit nr, input bit sr,
                          input int len, input logic [PW-1:0] p);
    if (m_rem > 0) begin
      m_place(p);
      m_rem--;
    end else if (sr) begin
      if (m_cnt != 0) m_flush();
      m_place(p);
      m_flush();
    end else if (br) begin
      m_vld[NS-1] = 1'b1;
      m_pay[(NS-1)*PW +: PW] = p;
      m_flush();
    end else if (cf) begin
      if (m_cnt + len > NS - 1) m_flush();
      m_place(p);
      m_rem = len - 1;
    end else if (nr) begin
      if (m_cnt == NS - 1) m_flush();
      m_place(p);
      m_flush();
    end else begin
      if (m_cnt == NS - 1) m_flush();
      m_place(p);
    end
  endtask

  task automatic send_op(input bit br, input bit cf, input bit nr, input bit sr,
                         input int len);
    logic [PW-1:0] p;
    nid = nid % 255 + 1;
    p = PW'(nid);
    @(posedge clk); #1;
    in_valid = 1'b1; in_pay = p; in_branch = br; in_crack_first = cf;
    in_nonren = nr; in_serialize = sr; in_crack_len = LW'(len);
    model_op(br, cf, nr, sr, len, p);
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic gap_only(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (m_cnt > 0 && m_rem == 0) m_flush();
    repeat (n) @(posedge clk);
  endtask

  task automatic send_crack(input int len, input bit junk);
    send_op(1'b0, 1'b1, 1'b0, 1'b0, len);
    for (int k = 1; k < len; k++) begin
      if (junk) send_op(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                        1'($urandom % 2), 1 + int'($urandom % 4));
      else      send_op(1'b0, 1'b0, 1'b0, 1'b0, 1);
    end
  endtask

  task automatic plains(input int n);
    for (int k = 0; k < n; k++) send_op(1'b0, 1'b0, 1'b0, 1'b0, 1);
  endtask

  // resource-available driver
  initial begin
    disp_ok = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (dmode)
        0:       disp_ok = 1'b1;
        1:       disp_ok = ($urandom % 10) < 7;
        default: disp_ok = 1'b0;
      endcase
    end
  end

  // output monitor
  logic             prev_hold = 1'b0;
  logic [GW-1:0]    prev_out  = '0;
  always @(negedge clk) begin
    if (!rst) begin
      logic [GW-1:0] cur;
      logic [GW-1:0] e;
      cur = {grp_slot_vld, grp_slot_pay};
      if (prev_hold)
        check(grp_valid && cur == prev_out, "R7 hold", cur, prev_out);
      if (grp_valid && disp_ok) begin
        if (expq.size() == 0) begin
          check(1'b0, {phase, " unexpected group"}, cur, '0);
        end else begin
          e = expq.pop_front();
          check(cur == e, phase, cur, e);
        end
      end
      prev_hold = grp_valid && !disp_ok;
      prev_out  = cur;
    end else begin
      prev_hold = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    rst = 1'b1; in_valid = 1'b0; in_pay = '0; in_branch = 1'b0;
    in_crack_first = 1'b0; in_nonren = 1'b0; in_serialize = 1'b0;
    in_crack_len = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!grp_valid && grp_slot_vld == '0, "R1 reset",
          GW'({grp_valid, grp_slot_vld}), '0);

    // R3: branch third, slots 2..3 NOP
    phase = "R3";
    plains(2); send_op(1'b1, 1'b0, 1'b0, 1'b0, 1); idle(4);
    send_op(1'b1, 1'b0, 1'b0, 1'b0, 1); idle(4);
    // R2: fifth non-branch opens a new group
    phase = "R2";
    plains(5); idle(4);
    // R9: full group with branch last
    phase = "R9";
    plains(4); send_op(1'b1, 1'b0, 1'b0, 1'b0, 1); idle(4);
    // R4: crack that does not fit
    phase = "R4";
    plains(2); send_crack(3, 1'b0); idle(4);
    plains(1); send_crack(3, 1'b0); plains(1); idle(4);
    // R5: non-renamed writer closes
    phase = "R5";
    plains(1); send_op(1'b0, 1'b0, 1'b1, 1'b0, 1); plains(1); idle(4);
    plains(4); send_op(1'b0, 1'b0, 1'b1, 1'b0, 1); idle(4);
    // R6: serializing singleton
    phase = "R6";
    plains(1); send_op(1'b0, 1'b0, 1'b0, 1'b1, 1); plains(1); idle(4);
    send_op(1'b0, 1'b0, 1'b0, 1'b1, 1); send_op(1'b0, 1'b0, 1'b0, 1'b1, 1); idle(4);
    // R10: member tags ignored, priority among tags
    phase = "R10";
    send_crack(4, 1'b1); idle(4);
    plains(1); send_op(1'b1, 1'b1, 1'b1, 1'b1, 2); idle(4);
    plains(1); send_op(1'b0, 1'b1, 1'b1, 1'b0, 2); plains(1); idle(4);
    // R8: idle flush, not inside a crack
    phase = "R8";
    plains(2); idle(4);
    send_op(1'b0, 1'b1, 1'b0, 1'b0, 2); gap_only(3); plains(1); idle(4);
    // R7: hold while resources are missing
    phase = "R7";
    dmode = 2; @(posedge clk);
    plains(1); send_op(1'b1, 1'b0, 1'b0, 1'b0, 1); plains(2); idle(8);
    dmode = 0; idle(6);
    // R11: random tagged stream against the model
    phase = "R11";
    dmode = 1;
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 8)       plains(1);
      else if (r < 11) send_op(1'b1, 1'b0, 1'b0, 1'b0, 1);
      else if (r < 13) send_op(1'b0, 1'b0, 1'b1, 1'b0, 1);
      else if (r < 15) send_op(1'b0, 1'b0, 1'b0, 1'b1, 1);
      else             send_crack(1 + int'($urandom % 4), 1'($urandom % 2));
      if (($urandom % 50) == 0) idle(2);
    end
    idle(2);
    dmode = 0;
    for (int w = 0; w < 200 && (expq.size() != 0 || grp_valid); w++) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0 && !grp_valid, "R11 drain",
          GW'(expq.size()), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule